// File: doc/BRIEF.md
# Two-Clock Dual-Port Word Memory with Selectable Read Latency

This block is a word-organised memory with two completely independent access ports, A and B, each running on its own clock. Either port can read or write any location at any time. The other port sees the result of a write as soon as the writing clock edge has passed. Each word is split into a lower and an upper byte lane. Writes touch only the lanes the caller enables. Read data appears on a per-lane drive-enable output next to a plain data-out vector, so the surrounding logic can build a tri-state or multiplexed bus.

A port is selected only when its active-low enable is low and its active-high enable is high at the same rising edge. Every control, address and write-data input is sampled on the rising edge, except the output enable, which acts combinationally. A per-port mode input picks the read latency. Flow-through returns the word in the cycle after the address edge. Pipelined adds one output register, so data and drive enables follow the controls of one edge earlier. The address comes from an external burst or address generator.

Top module: `twin_clock_ram`

## Requirements
- R1: A port is selected at a rising edge only when its `ce_n` is 0 and its `ce_p` is 1 at that edge. Any other combination performs no write and produces no drive on the following cycles.
- R2: When selected, `rnw`=0 at the edge writes the sampled `wdata` to the sampled address, and `rnw`=1 performs a read.
- R3: With `pipe`=0 sampled at the last edge (flow-through), `rdata` shows the word at the address sampled at that edge, valid until the next edge of the same port.
- R4: With `pipe`=1 sampled at the last edge (pipelined), `rdata` shows the word read at the address sampled one edge earlier, captured at the later edge.
- R5: `lane_n[0]` (active low) enables bits [LANE_W-1:0] and `lane_n[1]` enables bits [2*LANE_W-1:LANE_W]. A write leaves every disabled lane unchanged.
- R6: `drive[i]` is 1 only for a selected read whose sampled `lane_n[i]` was 0, and only while `oe_n` is 0. `oe_n` acts combinationally.
- R7: In pipelined mode, selection, deselection and lane choice reach `drive` one port clock later than in flow-through mode.
- R8: A word written by one port is returned by a read on the other port whose address edge, or output-capture edge in pipelined mode, comes after the write edge.
- R9: While `rst_n` is low, and until the first selected read after its release, both `drive` outputs are 0.
- R10: The `pipe` input is sampled on the rising edge. A change takes effect from the next edge of that port and may happen between any two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside each port |
| a_clk | input | 1 | Port A clock |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 2*LANE_W | Port A write data |
| a_rnw | input | 1 | Port A: 1 read, 0 write |
| a_ce_n | input | 1 | Port A active-low enable |
| a_ce_p | input | 1 | Port A active-high enable |
| a_lane_n | input | 2 | Port A active-low lane selects (bit 0 lower lane) |
| a_oe_n | input | 1 | Port A active-low output enable, combinational |
| a_pipe | input | 1 | Port A mode: 0 flow-through, 1 pipelined |
| a_rdata | output | 2*LANE_W | Port A read data |
| a_drive | output | 2 | Port A per-lane drive enables |
| b_clk | input | 1 | Port B clock |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 2*LANE_W | Port B write data |
| b_rnw | input | 1 | Port B: 1 read, 0 write |
| b_ce_n | input | 1 | Port B active-low enable |
| b_ce_p | input | 1 | Port B active-high enable |
| b_lane_n | input | 2 | Port B active-low lane selects (bit 0 lower lane) |
| b_oe_n | input | 1 | Port B active-low output enable, combinational |
| b_pipe | input | 1 | Port B mode: 0 flow-through, 1 pipelined |
| b_rdata | output | 2*LANE_W | Port B read data |
| b_drive | output | 2 | Port B per-lane drive enables |

## Verification
On every edge of each port clock, the assertions check that any active drive enable comes with a low output enable. They also check that it traces back, one or two edges earlier, to a selected read with that lane enabled. Data values, the exact latency per mode, lane masking on writes, writes that are ignored on deselect, and cross-port visibility under two skewed clocks are shown only by the bench scenarios. There, a behavioural model of the memory contents and of both latency paths is compared against every driven lane.

// File: rtl/twin_ram_pkg.sv
package twin_ram_pkg;

  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_mode_e;

  // A port takes part in a cycle only when both enables agree.
  function automatic logic port_picked(input logic ce_n, input logic ce_p);
    return (!ce_n) && ce_p;
  endfunction

endpackage

// File: rtl/twin_ram_rst_sync.sv
module twin_ram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/twin_ram_port_capture.sv
module twin_ram_port_capture
  import twin_ram_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             ce_n,
  input  logic             ce_p,
  input  logic             rnw,
  input  logic [LANES-1:0] lane_n,
  input  logic             pipe_sel,
  input  logic [AW-1:0]    addr,
  output logic             wr_go,
  output logic [LANES-1:0] wr_lanes,
  output logic             rd_q,
  output logic [LANES-1:0] lane_n_q,
  output logic [AW-1:0]    addr_q,
  output rd_mode_e         mode_q
);

  logic             picked;
  logic             rd_d;
  logic             addr_en;
  logic [AW-1:0]    addr_d;
  logic [LANES-1:0] lane_n_d;
  rd_mode_e         mode_d;

  always_comb begin
    picked   = port_picked(ce_n, ce_p);
    wr_go    = picked && !rnw && srst_n;
    wr_lanes = ~lane_n;
    rd_d     = picked && rnw;
    addr_en  = picked;
    addr_d   = addr;
    lane_n_d = lane_n;
    mode_d   = rd_mode_e'(pipe_sel);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_q     <= 1'b0;
      lane_n_q <= '1;
      mode_q   <= RD_FLOW;
    end else begin
      rd_q     <= rd_d;
      lane_n_q <= lane_n_d;
      mode_q   <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/twin_ram_bank.sv
module twin_ram_bank #(
  parameter int AW    = 10,
  parameter int DW    = 18,
  parameter int LANES = 2,
  parameter int NRD   = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  we_lanes,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wword,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*DW-1:0] rword
);

  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / LANES;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (we_lanes[l]) begin
          cells[waddr][l*LW +: LW] <= wword[l*LW +: LW];
        end
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rword[r*DW +: DW] = cells[raddr[r*AW +: AW]];
  end

endmodule

// File: rtl/twin_ram_read_out.sv
module twin_ram_read_out
  import twin_ram_pkg::*;
#(
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [DW-1:0]    word,
  input  logic             rd_q,
  input  logic [LANES-1:0] lane_n_q,
  input  rd_mode_e         mode_q,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic [LANES-1:0] drive
);

  logic             rd2_q;
  logic [LANES-1:0] lane_n2_q;
  logic [DW-1:0]    data2_q;
  logic             data2_en;
  logic             rd_sel;
  logic [LANES-1:0] lane_sel_n;

  always_comb begin
    data2_en = rd_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd2_q     <= 1'b0;
      lane_n2_q <= '1;
    end else begin
      rd2_q     <= rd_q;
      lane_n2_q <= lane_n_q;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      data2_q <= '0;
    end else if (data2_en) begin
      data2_q <= word;
    end
  end

  always_comb begin
    if (mode_q == RD_PIPE) begin
      rd_sel     = rd2_q;
      lane_sel_n = lane_n2_q;
      rdata      = data2_q;
    end else begin
      rd_sel     = rd_q;
      lane_sel_n = lane_n_q;
      rdata      = word;
    end
    for (int l = 0; l < LANES; l++) begin
      drive[l] = rd_sel && !lane_sel_n[l] && !oe_n;
    end
  end

endmodule

// File: rtl/twin_clock_ram.sv
module twin_clock_ram
  import twin_ram_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int ADDR_W = 10
) (
  input  logic                  rst_n,
  input  logic                  a_clk,
  input  logic [ADDR_W-1:0]     a_addr,
  input  logic [2*LANE_W-1:0]   a_wdata,
  input  logic                  a_rnw,
  input  logic                  a_ce_n,
  input  logic                  a_ce_p,
  input  logic [1:0]            a_lane_n,
  input  logic                  a_oe_n,
  input  logic                  a_pipe,
  output logic [2*LANE_W-1:0]   a_rdata,
  output logic [1:0]            a_drive,
  input  logic                  b_clk,
  input  logic [ADDR_W-1:0]     b_addr,
  input  logic [2*LANE_W-1:0]   b_wdata,
  input  logic                  b_rnw,
  input  logic                  b_ce_n,
  input  logic                  b_ce_p,
  input  logic [1:0]            b_lane_n,
  input  logic                  b_oe_n,
  input  logic                  b_pipe,
  output logic [2*LANE_W-1:0]   b_rdata,
  output logic [1:0]            b_drive
);

  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;
  localparam int NPORT  = 2;
  localparam int NRD    = 1 + NPORT;

  logic                clk_v    [NPORT];
  logic [ADDR_W-1:0]   addr_v   [NPORT];
  logic [DATA_W-1:0]   wdata_v  [NPORT];
  logic                rnw_v    [NPORT];
  logic                ce_n_v   [NPORT];
  logic                ce_p_v   [NPORT];
  logic [LANES-1:0]    lane_n_v [NPORT];
  logic                oe_n_v   [NPORT];
  logic                pipe_v   [NPORT];
  logic [DATA_W-1:0]   rdata_v  [NPORT];
  logic [LANES-1:0]    drive_v  [NPORT];

  logic                srst_n_v [NPORT];
  logic                wr_go_v  [NPORT];
  logic [LANES-1:0]    wr_ln_v  [NPORT];
  logic                rd_q_v   [NPORT];
  logic [LANES-1:0]    ln_q_v   [NPORT];
  logic [ADDR_W-1:0]   addr_q_v [NPORT];
  rd_mode_e            mode_q_v [NPORT];
  logic [DATA_W-1:0]   word_v   [NPORT];
  logic [DATA_W-1:0]   bwr_v    [NPORT];
  logic [NRD*ADDR_W-1:0] bank_ra [NPORT];
  logic [NRD*DATA_W-1:0] bank_rd [NPORT];

  assign clk_v[0]    = a_clk;
  assign addr_v[0]   = a_addr;
  assign wdata_v[0]  = a_wdata;
  assign rnw_v[0]    = a_rnw;
  assign ce_n_v[0]   = a_ce_n;
  assign ce_p_v[0]   = a_ce_p;
  assign lane_n_v[0] = a_lane_n;
  assign oe_n_v[0]   = a_oe_n;
  assign pipe_v[0]   = a_pipe;
  assign a_rdata     = rdata_v[0];
  assign a_drive     = drive_v[0];

  assign clk_v[1]    = b_clk;
  assign addr_v[1]   = b_addr;
  assign wdata_v[1]  = b_wdata;
  assign rnw_v[1]    = b_rnw;
  assign ce_n_v[1]   = b_ce_n;
  assign ce_p_v[1]   = b_ce_p;
  assign lane_n_v[1] = b_lane_n;
  assign oe_n_v[1]   = b_oe_n;
  assign pipe_v[1]   = b_pipe;
  assign b_rdata     = rdata_v[1];
  assign b_drive     = drive_v[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    twin_ram_rst_sync #(.STAGES(2)) u_rst (
      .clk    (clk_v[p]),
      .arst_n (rst_n),
      .srst_n (srst_n_v[p])
    );

    twin_ram_port_capture #(.AW(ADDR_W), .LANES(LANES)) u_cap (
      .clk      (clk_v[p]),
      .srst_n   (srst_n_v[p]),
      .ce_n     (ce_n_v[p]),
      .ce_p     (ce_p_v[p]),
      .rnw      (rnw_v[p]),
      .lane_n   (lane_n_v[p]),
      .pipe_sel (pipe_v[p]),
      .addr     (addr_v[p]),
      .wr_go    (wr_go_v[p]),
      .wr_lanes (wr_ln_v[p]),
      .rd_q     (rd_q_v[p]),
      .lane_n_q (ln_q_v[p]),
      .addr_q   (addr_q_v[p]),
      .mode_q   (mode_q_v[p])
    );

    // Bank p is written only by port p; its stored value is the new word
    // folded with the peer bank, so the XOR of both banks is the content.
    assign bank_ra[p] = {addr_q_v[1], addr_q_v[0], addr_v[1-p]};
    assign bwr_v[p]   = wdata_v[p] ^ bank_rd[1-p][0 +: DATA_W];

    twin_ram_bank #(.AW(ADDR_W), .DW(DATA_W), .LANES(LANES), .NRD(NRD)) u_bank (
      .clk      (clk_v[p]),
      .we       (wr_go_v[p]),
      .we_lanes (wr_ln_v[p]),
      .waddr    (addr_v[p]),
      .wword    (bwr_v[p]),
      .raddr    (bank_ra[p]),
      .rword    (bank_rd[p])
    );

    assign word_v[p] = bank_rd[0][(1+p)*DATA_W +: DATA_W]
                     ^ bank_rd[1][(1+p)*DATA_W +: DATA_W];

    twin_ram_read_out #(.DW(DATA_W), .LANES(LANES)) u_out (
      .clk      (clk_v[p]),
      .srst_n   (srst_n_v[p]),
      .word     (word_v[p]),
      .rd_q     (rd_q_v[p]),
      .lane_n_q (ln_q_v[p]),
      .mode_q   (mode_q_v[p]),
      .oe_n     (oe_n_v[p]),
      .rdata    (rdata_v[p]),
      .drive    (drive_v[p])
    );
  end

endmodule

// File: rtl/twin_clock_ram_chk.sv
module twin_clock_ram_chk (
  input logic       rst_n,
  input logic       a_clk,
  input logic       a_rnw,
  input logic       a_ce_n,
  input logic       a_ce_p,
  input logic [1:0] a_lane_n,
  input logic       a_oe_n,
  input logic [1:0] a_drive,
  input logic       b_clk,
  input logic       b_rnw,
  input logic       b_ce_n,
  input logic       b_ce_p,
  input logic [1:0] b_lane_n,
  input logic       b_oe_n,
  input logic [1:0] b_drive
);

  // R6
  a_oe_gate_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_drive != 2'b00) |-> !a_oe_n);
  // R1
  a_sel_src_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_drive != 2'b00) |-> ($past(!a_ce_n && a_ce_p) || $past(!a_ce_n && a_ce_p, 2)));
  // R2
  a_read_src_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_drive != 2'b00) |-> ($past(a_rnw) || $past(a_rnw, 2)));
  // R6
  a_lane0_src_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    a_drive[0] |-> ($past(!a_lane_n[0]) || $past(!a_lane_n[0], 2)));
  // R6
  a_lane1_src_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    a_drive[1] |-> ($past(!a_lane_n[1]) || $past(!a_lane_n[1], 2)));

  // R6
  b_oe_gate_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
    (b_drive != 2'b00) |-> !b_oe_n);
  // R1
  b_sel_src_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
    (b_drive != 2'b00) |-> ($past(!b_ce_n && b_ce_p) || $past(!b_ce_n && b_ce_p, 2)));
  // R2
  b_read_src_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
    (b_drive != 2'b00) |-> ($past(b_rnw) || $past(b_rnw, 2)));
  // R6
  b_lane0_src_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
    b_drive[0] |-> ($past(!b_lane_n[0]) || $past(!b_lane_n[0], 2)));
  // R6
  b_lane1_src_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
    b_drive[1] |-> ($past(!b_lane_n[1]) || $past(!b_lane_n[1], 2)));

endmodule

bind twin_clock_ram twin_clock_ram_chk u_chk (
  .rst_n    (rst_n),
  .a_clk    (a_clk),
  .a_rnw    (a_rnw),
  .a_ce_n   (a_ce_n),
  .a_ce_p   (a_ce_p),
  .a_lane_n (a_lane_n),
  .a_oe_n   (a_oe_n),
  .a_drive  (a_drive),
  .b_clk    (b_clk),
  .b_rnw    (b_rnw),
  .b_ce_n   (b_ce_n),
  .b_ce_p   (b_ce_p),
  .b_lane_n (b_lane_n),
  .b_oe_n   (b_oe_n),
  .b_drive  (b_drive)
);

// File: tb/twin_clock_ram_tb.sv
module twin_clock_ram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LANE_W     = 9;
  localparam int ADDR_W     = 10;
  localparam int DW         = 2 * LANE_W;
  localparam int TOP        = (1 << ADDR_W) - 1;

  logic              rst_n;
  logic              clk [2];
  logic [ADDR_W-1:0] addr [2];
  logic [DW-1:0]     wdata [2];
  logic              rnw [2];
  logic              ce_n [2];
  logic              ce_p [2];
  logic [1:0]        lane_n [2];
  logic              oe_n [2];
  logic              pipe [2];
  logic [DW-1:0]     rdata [2];
  logic [1:0]        drive [2];

  twin_clock_ram #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_dut (
    .rst_n    (rst_n),
    .a_clk    (clk[0]),   .a_addr (addr[0]),  .a_wdata (wdata[0]),
    .a_rnw    (rnw[0]),   .a_ce_n (ce_n[0]),  .a_ce_p  (ce_p[0]),
    .a_lane_n (lane_n[0]),.a_oe_n (oe_n[0]),  .a_pipe  (pipe[0]),
    .a_rdata  (rdata[0]), .a_drive(drive[0]),
    .b_clk    (clk[1]),   .b_addr (addr[1]),  .b_wdata (wdata[1]),
    .b_rnw    (rnw[1]),   .b_ce_n (ce_n[1]),  .b_ce_p  (ce_p[1]),
    .b_lane_n (lane_n[1]),.b_oe_n (oe_n[1]),  .b_pipe  (pipe[1]),
    .b_rdata  (rdata[1]), .b_drive(drive[1])
  );

  // Behavioural reference: word store plus per-port latency state.
  logic [DW-1:0]     mem [1 << ADDR_W];
  bit                m_rd1 [2];
  logic [1:0]        m_ln1 [2];
  logic [ADDR_W-1:0] m_ad1 [2];
  bit                m_mode [2];
  bit                m_rd2 [2];
  logic [1:0]        m_ln2 [2];
  logic [DW-1:0]     m_dat2 [2];

  int    wr_pct [2];
  int    ce_kind [2];
  int    mode_kind [2];
  int    oe_kind [2];
  int    lane_kind [2];
  int    seq_kind [2];
  int    seq_ad [2];
  string tag;
  int    checks;
  int    bad;
  bit    finished;

  initial begin
    clk[0] = 1'b0;
    forever #(CLK_PERIOD/2) clk[0] = ~clk[0];
  end
  initial begin
    clk[1] = 1'b0;
    #3;
    forever #(CLK_PERIOD/2) clk[1] = ~clk[1];
  end

  task automatic model_edge(input int p);
    bit sel;
    if (!rst_n) begin
      m_rd1[p] = 0; m_ln1[p] = 2'b11; m_mode[p] = 0;
      m_rd2[p] = 0; m_ln2[p] = 2'b11;
    end else begin
      m_rd2[p] = m_rd1[p];
      m_ln2[p] = m_ln1[p];
      if (m_rd1[p]) m_dat2[p] = mem[m_ad1[p]];
      sel = !ce_n[p] && ce_p[p];
      if (sel && !rnw[p]) begin
        if (!lane_n[p][0]) mem[addr[p]][LANE_W-1:0]  = wdata[p][LANE_W-1:0];
        if (!lane_n[p][1]) mem[addr[p]][DW-1:LANE_W] = wdata[p][DW-1:LANE_W];
      end
      m_rd1[p]  = sel && rnw[p];
      m_ln1[p]  = lane_n[p];
      if (sel) m_ad1[p] = addr[p];
      m_mode[p] = pipe[p];
    end
  endtask

  always @(posedge clk[0]) model_edge(0);
  always @(posedge clk[1]) model_edge(1);

  task automatic compare(input int p);
    bit         r;
    logic [1:0] ln;
    logic [1:0] ed;
    logic [DW-1:0] ew;
    r  = m_mode[p] ? m_rd2[p] : m_rd1[p];
    ln = m_mode[p] ? m_ln2[p] : m_ln1[p];
    ew = m_mode[p] ? m_dat2[p] : mem[m_ad1[p]];
    for (int l = 0; l < 2; l++) ed[l] = r && !ln[l] && !oe_n[p];
    checks++;
    if (drive[p] !== ed) begin
      bad++;
      $display("FAIL %s port%0d drive act=%b exp=%b t=%0t", tag, p, drive[p], ed, $time);
    end
    for (int l = 0; l < 2; l++) begin
      if (ed[l]) begin
        checks++;
        if (rdata[p][l*LANE_W +: LANE_W] !== ew[l*LANE_W +: LANE_W]) begin
          bad++;
          $display("FAIL %s port%0d lane%0d data act=%h exp=%h t=%0t", tag, p, l,
                   rdata[p][l*LANE_W +: LANE_W], ew[l*LANE_W +: LANE_W], $time);
        end
      end
    end
  endtask

  task automatic drive_port(input int p);
    int r;
    case (ce_kind[p])
      0: begin ce_n[p] = 1'b1; ce_p[p] = 1'b0; end
      1: begin ce_n[p] = 1'b0; ce_p[p] = 1'b1; end
      default: begin ce_n[p] = 1'($urandom); ce_p[p] = 1'($urandom); end
    endcase
    rnw[p] = int'($urandom % 100) >= wr_pct[p];
    if (seq_kind[p] != 0) begin
      r = seq_ad[p];
      seq_ad[p] = (seq_ad[p] + 1) % 33;
    end else begin
      r = int'($urandom % 33);
    end
    addr[p]   = (r == 32) ? ADDR_W'(TOP) : ADDR_W'(r);
    wdata[p]  = DW'($urandom);
    lane_n[p] = (lane_kind[p] != 0) ? 2'($urandom) : 2'b00;
    oe_n[p]   = (oe_kind[p] != 0) ? 1'($urandom) : 1'b0;
    case (mode_kind[p])
      0: pipe[p] = 1'b0;
      1: pipe[p] = 1'b1;
      default: pipe[p] = 1'($urandom);
    endcase
  endtask

  always @(negedge clk[0]) if (!finished) begin compare(0); drive_port(0); end
  always @(negedge clk[1]) if (!finished) begin compare(1); drive_port(1); end

  task automatic knobs(input int p, input int wr, input int ce, input int md,
                       input int oe, input int ln, input int sq);
    wr_pct[p] = wr; ce_kind[p] = ce; mode_kind[p] = md;
    oe_kind[p] = oe; lane_kind[p] = ln; seq_kind[p] = sq; seq_ad[p] = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk[0]);
  endtask

  task automatic finish_run;
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++;
    checks++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    checks = 0; bad = 0; finished = 0;
    tag = "R9";
    for (int p = 0; p < 2; p++) begin
      knobs(p, 0, 0, 0, 0, 0, 0);
      addr[p] = '0; wdata[p] = '0; rnw[p] = 1'b1; ce_n[p] = 1'b1; ce_p[p] = 1'b0;
      lane_n[p] = 2'b00; oe_n[p] = 1'b0; pipe[p] = 1'b0;
    end
    rst_n = 1'b0;
    run(4);
    // R9: nothing driven while reset is held
    for (int p = 0; p < 2; p++) begin
      checks++;
      if (drive[p] !== 2'b00) begin
        bad++;
        $display("FAIL R9 port%0d reset drive act=%b exp=00", p, drive[p]);
      end
    end
    rst_n = 1'b1;
    run(5);
    // R9: still nothing driven after release with no read yet
    for (int p = 0; p < 2; p++) begin
      checks++;
      if (drive[p] !== 2'b00) begin
        bad++;
        $display("FAIL R9 port%0d post-release drive act=%b exp=00", p, drive[p]);
      end
    end

    tag = "R2";   // fill the tested address set from port A
    knobs(0, 100, 1, 0, 0, 0, 1);
    run(34);
    knobs(0, 0, 0, 0, 0, 0, 0);
    run(3);

    tag = "R3";   // flow-through reads on both ports
    knobs(0, 0, 1, 0, 0, 0, 1);
    knobs(1, 0, 1, 0, 0, 0, 0);
    run(60);

    tag = "R4";   // pipelined reads on both ports
    knobs(0, 0, 1, 1, 0, 0, 1);
    knobs(1, 0, 1, 1, 0, 0, 0);
    run(60);

    tag = "R5";   // lane-masked writes mixed with reads
    knobs(0, 40, 1, 0, 0, 1, 0);
    knobs(1, 40, 1, 0, 0, 1, 0);
    run(120);

    tag = "R6";   // output enable and lane gating on reads
    knobs(0, 0, 1, 2, 1, 1, 0);
    knobs(1, 0, 1, 2, 1, 1, 0);
    run(100);

    tag = "R1";   // all enable combinations, deselected writes must not land
    knobs(0, 50, 2, 0, 0, 0, 0);
    knobs(1, 50, 2, 0, 0, 0, 0);
    run(150);

    tag = "R7";   // pipelined with selection toggling
    knobs(0, 20, 2, 1, 0, 1, 0);
    knobs(1, 20, 2, 1, 0, 1, 0);
    run(120);

    tag = "R8";   // one port writes, the other reads the same set
    knobs(0, 100, 1, 0, 0, 0, 0);
    knobs(1, 0, 1, 0, 0, 0, 0);
    run(100);
    knobs(0, 0, 1, 1, 0, 0, 0);
    knobs(1, 100, 1, 0, 0, 1, 0);
    run(100);

    tag = "R10";  // mode changes between any two accesses
    knobs(0, 30, 2, 2, 1, 1, 0);
    knobs(1, 30, 2, 2, 1, 1, 0);
    run(300);

    finish_run();
  end

endmodule